// File: doc/BRIEF.md
# Masked Fixed-Priority Interrupt Resolver

This block sits between eight peripheral request lines and a processor interrupt input. It samples the lines every clock into a request register and hides any line whose mask bit is set. Among the visible requests it chooses the lowest-numbered one, because line 0 has the highest priority. It raises its interrupt output only when that request outranks every level that is already being serviced. The index of the chosen level is driven alongside the interrupt so that the processor side can form a vector.

When the processor finishes its acknowledge sequence, it pulses an acknowledge-done strobe. The block then records the chosen level as in service and drops its request bit for that cycle. A level leaves service through a non-specific end-of-interrupt strobe, which retires the highest-priority level in service. In automatic mode the level leaves service when the acknowledge ends, so no end-of-interrupt strobe is needed. Lower-priority work is held off while a level is in service, and higher-priority work can still nest on top of it.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The request register takes the value of the request lines on every clock, with bit i holding line i. A line that drops before it is acknowledged no longer causes an interrupt one clock later.
- R2: A mask bit of 1 stops the matching line from being chosen or from raising the interrupt. Masking one line has no effect on whether any other line is chosen.
- R3: Priority is fixed, with line 0 the highest and line 7 the lowest. While the interrupt is high, `level_o` gives the lowest index among the unmasked pending requests.
- R4: The interrupt is high only when an unmasked request is pending and its index is strictly lower than every index set in the in-service register. A request at the same level as one in service does not raise the interrupt.
- R5: In normal mode, an acknowledge taken while the interrupt is high sets the in-service bit of the chosen level. The same acknowledge clears that level's request bit for one clock.
- R6: In automatic mode (`auto_eoi_i` = 1), an acknowledge leaves the in-service register unchanged, so lower-priority requests can be served right away.
- R7: The end-of-interrupt strobe clears the lowest-indexed set bit of the in-service register. When no bit is set, it has no effect.
- R8: After reset the mask, request and in-service registers are all zero and the interrupt is low.
- R9: A mask write takes effect on the next clock and can drop an interrupt that is already asserted.
- R10: An acknowledge that arrives while the interrupt is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Level-sensitive request lines, bit i is line i |
| mask_wr_i | input | 1 | Loads `mask_data_i` into the mask register |
| mask_data_i | input | 8 | New mask value, 1 blocks the line |
| eoi_i | input | 1 | Non-specific end-of-interrupt strobe |
| ack_i | input | 1 | Acknowledge-done strobe from the processor side |
| auto_eoi_i | input | 1 | 1 selects automatic end of interrupt |
| irq_o | output | 1 | Interrupt request toward the processor |
| level_o | output | 3 | Index of the chosen request |

## Verification
Nearly all of the block's state is visible only through `irq_o` and `level_o`. A wrong in-service bit therefore shows up as an interrupt that is wrongly held off, or wrongly let through, when the next request arrives. That error appears one clock after the stimulus that exposes it. A wrong request or mask bit shows up within one clock as the wrong level or a missing interrupt. An in-service bit that wrongly stays set after an end-of-interrupt blocks every lower-priority line until the following strobe. The bench makes each such bit visible by raising a probe request just below or just above the level in question.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int LINES = 8;
    localparam int IDX_W = $clog2(LINES);

    typedef struct packed {
        logic [LINES-1:0] mask;
        logic [LINES-1:0] irr;
        logic [LINES-1:0] isr;
    } irqc_state_t;
endpackage

// File: rtl/irqc_first_set.sv
// Finds the lowest-indexed set bit (highest priority) of a vector.
module irqc_first_set #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic         hit,
    output logic [W-1:0] idx,
    output logic [N-1:0] onehot
);
    always_comb begin
        hit = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = W'(i);
        end
        onehot = hit ? (N'(1) << idx) : '0;
    end
endmodule

// File: rtl/irqc_gate.sv
// Lets a winning request through only if it outranks the level in service.
module irqc_gate #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic         win_hit,
    input  logic [W-1:0] win_idx,
    input  logic         svc_hit,
    input  logic [W-1:0] svc_idx,
    output logic         irq
);
    always_comb begin
        irq = win_hit && (!svc_hit || (win_idx < svc_idx));
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int N = irqc_pkg::LINES,
    localparam int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic         mask_wr_i,
    input  logic [N-1:0] mask_data_i,
    input  logic         eoi_i,
    input  logic         ack_i,
    input  logic         auto_eoi_i,
    output logic         irq_o,
    output logic [W-1:0] level_o
);
    irqc_state_t st_q, st_d;

    logic [N-1:0] pending;
    logic         win_hit, svc_hit;
    logic [W-1:0] win_idx, svc_idx;
    logic [N-1:0] win_oh, svc_oh;
    logic         take;
    logic [N-1:0] isr_clr, isr_set;

    assign pending = st_q.irr & ~st_q.mask;

    irqc_first_set #(.N(N)) u_win (
        .vec    (pending),
        .hit    (win_hit),
        .idx    (win_idx),
        .onehot (win_oh)
    );

    irqc_first_set #(.N(N)) u_svc (
        .vec    (st_q.isr),
        .hit    (svc_hit),
        .idx    (svc_idx),
        .onehot (svc_oh)
    );

    irqc_gate #(.N(N)) u_gate (
        .win_hit (win_hit),
        .win_idx (win_idx),
        .svc_hit (svc_hit),
        .svc_idx (svc_idx),
        .irq     (irq_o)
    );

    assign level_o = win_idx;

    always_comb begin
        st_d    = st_q;
        take    = ack_i && irq_o;
        isr_clr = eoi_i ? svc_oh : '0;
        isr_set = (take && !auto_eoi_i) ? win_oh : '0;

        st_d.irr = take ? (req_i & ~win_oh) : req_i;
        if (mask_wr_i) st_d.mask = mask_data_i;
        st_d.isr = (st_q.isr & ~isr_clr) | isr_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mask_wr_i,
    input logic [N-1:0] mask_data_i,
    input logic         eoi_i,
    input logic         ack_i,
    input logic         auto_eoi_i,
    input logic         irq_o,
    input logic [W-1:0] level_o,
    input logic [N-1:0] mask_q,
    input logic [N-1:0] irr_q,
    input logic [N-1:0] isr_q
);
    logic [N-1:0] at_or_above;
    always_comb begin
        at_or_above = '0;
        for (int i = 0; i < N; i++) begin
            if (W'(i) <= level_o) at_or_above[i] = 1'b1;
        end
    end

    AST_WIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irr_q[level_o]);                                          // R1
    AST_WIN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !mask_q[level_o]);                                        // R2
    AST_IRQ_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((isr_q & at_or_above) == '0));                           // R4
    AST_ACK_SETS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && !auto_eoi_i) |=> isr_q[$past(level_o)]);         // R5
    AST_AUTO_KEEPS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && auto_eoi_i && !eoi_i) |=> (isr_q == $past(isr_q)));       // R6
    AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !ack_i && (isr_q != '0))
        |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));           // R7
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_i |=> (mask_q == $past(mask_data_i)));                      // R9
    AST_IDLE_ACK_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_o && !eoi_i) |=> (isr_q == $past(isr_q)));           // R10
endmodule

bind prio_irq_ctrl irqc_checker #(.N(N)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_wr_i   (mask_wr_i),
    .mask_data_i (mask_data_i),
    .eoi_i       (eoi_i),
    .ack_i       (ack_i),
    .auto_eoi_i  (auto_eoi_i),
    .irq_o       (irq_o),
    .level_o     (level_o),
    .mask_q      (st_q.mask),
    .irr_q       (st_q.irr),
    .isr_q       (st_q.isr)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req_i;
    logic       mask_wr_i;
    logic [7:0] mask_data_i;
    logic       eoi_i;
    logic       ack_i;
    logic       auto_eoi_i;
    logic       irq_o;
    logic [2:0] level_o;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_wr_i(mask_wr_i),
        .mask_data_i(mask_data_i), .eoi_i(eoi_i), .ack_i(ack_i),
        .auto_eoi_i(auto_eoi_i), .irq_o(irq_o), .level_o(level_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        mask_wr_i = 1'b0;
        eoi_i     = 1'b0;
        ack_i     = 1'b0;
    endtask

    task automatic chk(input string tag, input logic exp_irq, input logic [2:0] exp_lvl);
        tests++;
        if (irq_o !== exp_irq || (exp_irq && level_o !== exp_lvl)) begin
            fails++;
            $display("FAIL %s actual irq=%0b level=%0d expected irq=%0b level=%0d",
                     tag, irq_o, level_o, exp_irq, exp_lvl);
        end
    endtask

    task automatic do_mask(input logic [7:0] m);
        mask_wr_i = 1'b1; mask_data_i = m; tick();
    endtask

    task automatic t_reset();
        chk("R8 reset idle", 1'b0, 3'd0);
    endtask

    task automatic t_priority();
        req_i = 8'b1010_0000; tick();
        chk("R1 R3 lines 5,7", 1'b1, 3'd5);
        req_i = 8'hFF; tick();
        chk("R3 all lines", 1'b1, 3'd0);
        req_i = 8'h80; tick();
        chk("R3 lowest line", 1'b1, 3'd7);
        req_i = 8'h00; tick();
        chk("R1 line dropped", 1'b0, 3'd0);
    endtask

    task automatic t_mask();
        do_mask(8'h01);
        req_i = 8'h03; tick();
        chk("R2 mask line0 keeps line1", 1'b1, 3'd1);
        do_mask(8'hFF);
        chk("R2 all masked", 1'b0, 3'd0);
        do_mask(8'h00);
        chk("R9 unmask", 1'b1, 3'd0);
        do_mask(8'h03);
        chk("R9 mask drops asserted irq", 1'b0, 3'd0);
        do_mask(8'h00);
        req_i = 8'h00; tick();
    endtask

    task automatic t_nested();
        auto_eoi_i = 1'b0;
        req_i = 8'h10; tick();
        chk("R4 level4 raised", 1'b1, 3'd4);
        ack_i = 1'b1; tick();
        tick();
        chk("R5 R4 same level held off", 1'b0, 3'd0);
        req_i = 8'h14; tick();
        chk("R4 level2 outranks 4", 1'b1, 3'd2);
        ack_i = 1'b1; req_i = 8'h18; tick();
        chk("R4 level3 below level2 held", 1'b0, 3'd0);
        eoi_i = 1'b1; tick();
        chk("R7 eoi retires level2 first", 1'b1, 3'd3);
        req_i = 8'h40; tick();
        chk("R7 level4 still in service", 1'b0, 3'd0);
        eoi_i = 1'b1; tick();
        chk("R7 second eoi frees level6", 1'b1, 3'd6);
        eoi_i = 1'b1; tick();
        chk("R7 eoi with empty service", 1'b1, 3'd6);
        req_i = 8'h00; tick();
    endtask

    task automatic t_auto();
        auto_eoi_i = 1'b1;
        req_i = 8'h08; tick();
        chk("R6 level3 raised", 1'b1, 3'd3);
        ack_i = 1'b1; req_i = 8'h20; tick();
        chk("R6 no service bit kept", 1'b1, 3'd5);
        auto_eoi_i = 1'b0;
        req_i = 8'h00; tick();
    endtask

    task automatic t_idle_ack();
        req_i = 8'h00; ack_i = 1'b1; tick();
        req_i = 8'h80; tick();
        chk("R10 idle ack ignored", 1'b1, 3'd7);
        ack_i = 1'b1; req_i = 8'h00; tick();
        req_i = 8'h80; tick();
        chk("R5 request cleared then re-sampled held", 1'b0, 3'd0);
        eoi_i = 1'b1; tick();
        chk("R7 release level7", 1'b1, 3'd7);
        req_i = 8'h00; tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_i = '0; mask_wr_i = 1'b0; mask_data_i = '0;
        eoi_i = 1'b0; ack_i = 1'b0; auto_eoi_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_priority();
        t_mask();
        t_nested();
        t_auto();
        t_idle_ack();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule